// File: doc/BRIEF.md
# Address-Indexed Instrumentation Event Monitor

The monitor follows a processor's fetch address stream without ever holding it back. Each fetch address that falls inside a configurable window selects one byte in a local shadow memory that mirrors the code map location for location. That byte holds a small instrumentation opcode and a resource ID. Executing the opcode in step with the fetches lets any code location set or clear a flag, test a flag, bump a statistics counter, start or stop an elapsed-time timer, or raise an event.

Every event becomes a record in a small trace FIFO. A record holds the fetch timestamp, the window index, the ID, the opcode, a data value and a snapshot of CPU state taken with the fetch. The FIFO drains through a valid/ready stream. When the FIFO is full, new records are discarded and the loss is reported. Software-side tooling fills the shadow memory through a separate write port.

Top module: `instr_event_mon`

## Requirements
- R1: A fetch acts only when `fetch_valid_i` is high and every address bit above the low `WIN_W` bits is zero. The low `WIN_W` bits select exactly one shadow entry, including the top index 2^WIN_W-1. Any other fetch has no effect.
- R2: Bits [7:4] of an entry hold the opcode and bits [3:0] hold the ID. The opcodes are: 0 no-op, 1 set flag[ID], 2 clear flag[ID], 3 emit if flag[ID] is set, 4 emit, 5 increment counter[ID], 6 start timer[ID], 7 stop timer[ID] and emit.
- R3: The block accepts a fetch in every cycle and has no stall output. The record of an emitting fetch enters the FIFO one clock after the fetch, and fetches on consecutive cycles execute in order.
- R4: Opcode 3 emits only if the flag has been set by opcode 1 and not cleared since by opcode 2. Each flag is written only by opcodes naming its ID, and all flags are clear after reset.
- R5: Opcodes 3 and 4 emit a record whose value field is the current counter[ID].
- R6: Opcode 5 adds one to counter[ID], wrapping at VAL_W bits, and emits nothing. All counters are zero after reset.
- R7: Opcode 7 emits a record whose value field is its own timestamp minus the timestamp stored by the last opcode 6 on the same ID, modulo 2^VAL_W. Opcode 6 emits nothing.
- R8: A record carries the following fields. The timestamp counts clock edges since reset release: the fetch sampled at the first edge gets 0. The other fields are the window index, the ID, the opcode, and the value of `cpu_state_i` sampled with the fetch.
- R9: Opcodes 8 to 15 emit nothing and change no flag, counter or timer.
- R10: A record that arrives while the FIFO holds FIFO_DEPTH records is discarded. `ovf_o` then goes high and stays high until reset, and `drop_cnt_o` counts the discarded records, saturating at its maximum.
- R11: A shadow write and a lookup of the same index in the same cycle return the old entry. The new entry applies from the next lookup on.
- R12: Records leave in arrival order. A record is removed in a cycle where `evt_valid_o` and `evt_ready_i` are both high. While it waits it stays unchanged. After reset the FIFO is empty and `ovf_o` and `drop_cnt_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_valid_i | input | 1 | Fetch address strobe |
| fetch_addr_i | input | ADDR_W | Fetch word address |
| cpu_state_i | input | STATE_W | CPU state captured with the fetch |
| cfg_we_i | input | 1 | Shadow memory write enable |
| cfg_addr_i | input | WIN_W | Shadow memory write index |
| cfg_data_i | input | 8 | Entry: opcode [7:4], ID [3:0] |
| evt_ready_i | input | 1 | Consumer accepts the head record |
| evt_valid_o | output | 1 | Head record present |
| evt_ts_o | output | VAL_W | Record timestamp |
| evt_addr_o | output | WIN_W | Record window index |
| evt_id_o | output | 4 | Record ID |
| evt_op_o | output | 4 | Record opcode |
| evt_val_o | output | VAL_W | Counter value or elapsed time |
| evt_state_o | output | STATE_W | Captured CPU state |
| ovf_o | output | 1 | Sticky discard indication |
| drop_cnt_o | output | DROP_W | Discarded record count |

## Verification
The following are checked on every cycle:
- `ovf_o` is sticky and the discard count never decreases.
- A newly raised overflow comes with a nonzero count.
- A waiting head record holds steady.
- No record is generated by a cycle without a valid in-window fetch.

The scenarios cover what needs history:
- the effect of flags across fetches;
- counter totals and timer differences;
- the exact timestamp and state in each record;
- inert reserved opcodes;
- the read-before-write collision;
- the drop count after the FIFO fills, and ordered draining afterwards.

// File: rtl/instr_mon_pkg.sv
package instr_mon_pkg;
  localparam int OP_W    = 4;
  localparam int ID_W    = 4;
  localparam int ENTRY_W = OP_W + ID_W;

  typedef enum logic [OP_W-1:0] {
    OP_NOP    = 4'd0,
    OP_SET    = 4'd1,
    OP_CLR    = 4'd2,
    OP_TEST   = 4'd3,
    OP_EMIT   = 4'd4,
    OP_INC    = 4'd5,
    OP_TSTART = 4'd6,
    OP_TSTOP  = 4'd7
  } op_e;
endpackage

// File: rtl/instr_mon_shadow.sv
module instr_mon_shadow
  import instr_mon_pkg::*;
#(
  parameter int WIN_W = 10
) (
  input  logic               clk_i,
  input  logic               we_i,
  input  logic [WIN_W-1:0]   waddr_i,
  input  logic [ENTRY_W-1:0] wdata_i,
  input  logic [WIN_W-1:0]   raddr_i,
  output logic [ENTRY_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << WIN_W;

  logic [ENTRY_W-1:0] mem_q [DEPTH];

  // read-before-write: same-cycle collision returns the old entry
  always_ff @(posedge clk_i) begin
    rdata_o <= mem_q[raddr_i];
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end
endmodule

// File: rtl/instr_mon_exec.sv
module instr_mon_exec
  import instr_mon_pkg::*;
#(
  parameter int VAL_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [OP_W-1:0]  op_i,
  input  logic [ID_W-1:0]  id_i,
  input  logic [VAL_W-1:0] ts_i,
  output logic             push_o,
  output logic [VAL_W-1:0] val_o
);
  localparam int NUM_RES = 1 << ID_W;

  logic [NUM_RES-1:0] flag_q;
  logic [VAL_W-1:0]   cnt_q   [NUM_RES];
  logic [VAL_W-1:0]   start_q [NUM_RES];

  for (genvar g = 0; g < NUM_RES; g++) begin : g_res
    logic hit;
    assign hit = valid_i && (id_i == ID_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        flag_q[g]  <= 1'b0;
        cnt_q[g]   <= '0;
        start_q[g] <= '0;
      end else if (hit) begin
        case (op_i)
          OP_SET:    flag_q[g]  <= 1'b1;
          OP_CLR:    flag_q[g]  <= 1'b0;
          OP_INC:    cnt_q[g]   <= cnt_q[g] + VAL_W'(1);
          OP_TSTART: start_q[g] <= ts_i;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    push_o = 1'b0;
    val_o  = cnt_q[id_i];
    if (valid_i) begin
      case (op_i)
        OP_TEST:  push_o = flag_q[id_i];
        OP_EMIT:  push_o = 1'b1;
        OP_TSTOP: begin
          push_o = 1'b1;
          val_o  = ts_i - start_q[id_i];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/instr_mon_fifo.sv
module instr_mon_fifo #(
  parameter int W      = 32,
  parameter int DEPTH  = 4,
  parameter int DROP_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [W-1:0]      din_i,
  input  logic              pop_i,
  output logic [W-1:0]      dout_o,
  output logic              valid_o,
  output logic              ovf_o,
  output logic [DROP_W-1:0] drop_cnt_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             full, do_push, do_pop;

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign valid_o = (cnt_q != '0);
  assign do_push = push_i && !full;
  assign do_pop  = pop_i && valid_o;
  assign dout_o  = mem_q[rd_q];

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q       <= '0;
      rd_q       <= '0;
      cnt_q      <= '0;
      ovf_o      <= 1'b0;
      drop_cnt_o <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      cnt_q <= cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
      if (push_i && full) begin
        ovf_o <= 1'b1;
        if (drop_cnt_o != '1) drop_cnt_o <= drop_cnt_o + DROP_W'(1);
      end
    end
  end
endmodule

// File: rtl/instr_event_mon.sv
module instr_event_mon
  import instr_mon_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WIN_W      = 10,
  parameter int VAL_W      = 16,
  parameter int STATE_W    = 8,
  parameter int FIFO_DEPTH = 4,
  parameter int DROP_W     = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fetch_valid_i,
  input  logic [ADDR_W-1:0]  fetch_addr_i,
  input  logic [STATE_W-1:0] cpu_state_i,
  input  logic               cfg_we_i,
  input  logic [WIN_W-1:0]   cfg_addr_i,
  input  logic [ENTRY_W-1:0] cfg_data_i,
  input  logic               evt_ready_i,
  output logic               evt_valid_o,
  output logic [VAL_W-1:0]   evt_ts_o,
  output logic [WIN_W-1:0]   evt_addr_o,
  output logic [ID_W-1:0]    evt_id_o,
  output logic [OP_W-1:0]    evt_op_o,
  output logic [VAL_W-1:0]   evt_val_o,
  output logic [STATE_W-1:0] evt_state_o,
  output logic               ovf_o,
  output logic [DROP_W-1:0]  drop_cnt_o
);
  localparam int REC_W = 2 * VAL_W + WIN_W + ID_W + OP_W + STATE_W;

  logic               in_win, lookup;
  logic [VAL_W-1:0]   ts_q;
  logic               s1_valid_q;
  logic [WIN_W-1:0]   s1_idx_q;
  logic [STATE_W-1:0] s1_state_q;
  logic [VAL_W-1:0]   s1_ts_q;
  logic [ENTRY_W-1:0] entry;
  logic               ex_push;
  logic [VAL_W-1:0]   ex_val;
  logic [REC_W-1:0]   rec_in, rec_out;

  assign in_win = ~|fetch_addr_i[ADDR_W-1:WIN_W];
  assign lookup = fetch_valid_i && in_win;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ts_q       <= '0;
      s1_valid_q <= 1'b0;
      s1_idx_q   <= '0;
      s1_state_q <= '0;
      s1_ts_q    <= '0;
    end else begin
      ts_q       <= ts_q + VAL_W'(1);
      s1_valid_q <= lookup;
      if (lookup) begin
        s1_idx_q   <= fetch_addr_i[WIN_W-1:0];
        s1_state_q <= cpu_state_i;
        s1_ts_q    <= ts_q;
      end
    end
  end

  instr_mon_shadow #(.WIN_W(WIN_W)) u_shadow (
    .clk_i   (clk_i),
    .we_i    (cfg_we_i),
    .waddr_i (cfg_addr_i),
    .wdata_i (cfg_data_i),
    .raddr_i (fetch_addr_i[WIN_W-1:0]),
    .rdata_o (entry)
  );

  instr_mon_exec #(.VAL_W(VAL_W)) u_exec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (s1_valid_q),
    .op_i    (entry[ENTRY_W-1:ID_W]),
    .id_i    (entry[ID_W-1:0]),
    .ts_i    (s1_ts_q),
    .push_o  (ex_push),
    .val_o   (ex_val)
  );

  assign rec_in = {s1_ts_q, s1_idx_q, entry[ID_W-1:0], entry[ENTRY_W-1:ID_W], ex_val, s1_state_q};

  instr_mon_fifo #(.W(REC_W), .DEPTH(FIFO_DEPTH), .DROP_W(DROP_W)) u_fifo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (ex_push),
    .din_i      (rec_in),
    .pop_i      (evt_ready_i),
    .dout_o     (rec_out),
    .valid_o    (evt_valid_o),
    .ovf_o      (ovf_o),
    .drop_cnt_o (drop_cnt_o)
  );

  assign {evt_ts_o, evt_addr_o, evt_id_o, evt_op_o, evt_val_o, evt_state_o} = rec_out;
endmodule

// File: rtl/instr_mon_chk.sv
module instr_mon_chk #(
  parameter int ADDR_W  = 32,
  parameter int WIN_W   = 10,
  parameter int REC_W   = 32,
  parameter int DROP_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fetch_valid_i,
  input logic [ADDR_W-1:0] fetch_addr_i,
  input logic              ex_push,
  input logic              evt_valid_o,
  input logic              evt_ready_i,
  input logic [REC_W-1:0]  rec_out,
  input logic              ovf_o,
  input logic [DROP_W-1:0] drop_cnt_o
);
  p_no_push_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_valid_i |=> !ex_push);

  p_no_push_outside_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_valid_i && |fetch_addr_i[ADDR_W-1:WIN_W]) |=> !ex_push);

  p_ovf_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);

  p_drop_monotonic_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> drop_cnt_o >= $past(drop_cnt_o));

  p_ovf_has_count_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> drop_cnt_o != '0);

  p_head_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_o && !evt_ready_i) |=> (evt_valid_o && $stable(rec_out)));
endmodule

bind instr_event_mon instr_mon_chk #(
  .ADDR_W (ADDR_W),
  .WIN_W  (WIN_W),
  .REC_W  (REC_W),
  .DROP_W (DROP_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .fetch_valid_i (fetch_valid_i),
  .fetch_addr_i  (fetch_addr_i),
  .ex_push       (ex_push),
  .evt_valid_o   (evt_valid_o),
  .evt_ready_i   (evt_ready_i),
  .rec_out       (rec_out),
  .ovf_o         (ovf_o),
  .drop_cnt_o    (drop_cnt_o)
);

// File: tb/instr_event_mon_bench.sv
module instr_event_mon_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32, WIN_W = 10, VAL_W = 16, STATE_W = 8, DEPTH = 4, DROP_W = 8;

  typedef struct {
    logic [VAL_W-1:0]   ts;
    logic [WIN_W-1:0]   addr;
    logic [3:0]         id;
    logic [3:0]         op;
    logic [VAL_W-1:0]   val;
    logic [STATE_W-1:0] state;
    string              tag;
  } rec_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fv = 1'b0, we = 1'b0, rdy = 1'b1;
  logic [ADDR_W-1:0]  fa = '0;
  logic [STATE_W-1:0] st = '0;
  logic [WIN_W-1:0]   wa = '0;
  logic [7:0]         wd = '0;
  logic               evt_valid, ovf;
  logic [VAL_W-1:0]   evt_ts, evt_val;
  logic [WIN_W-1:0]   evt_addr;
  logic [3:0]         evt_id, evt_op;
  logic [STATE_W-1:0] evt_state;
  logic [DROP_W-1:0]  drop_cnt;

  int errors = 0, checks = 0, cyc = 0, drop_exp = 0;
  rec_t q[$];
  logic [7:0]       m_mem [1 << WIN_W];
  logic [15:0]      m_flag = '0;
  logic [VAL_W-1:0] m_cnt [16];
  logic [VAL_W-1:0] m_start [16];
  string cur_tag = "";

  instr_event_mon u_instr_event_mon (
    .clk_i(clk), .rst_ni(rst_n), .fetch_valid_i(fv), .fetch_addr_i(fa),
    .cpu_state_i(st), .cfg_we_i(we), .cfg_addr_i(wa), .cfg_data_i(wd),
    .evt_ready_i(rdy), .evt_valid_o(evt_valid), .evt_ts_o(evt_ts),
    .evt_addr_o(evt_addr), .evt_id_o(evt_id), .evt_op_o(evt_op),
    .evt_val_o(evt_val), .evt_state_o(evt_state), .ovf_o(ovf), .drop_cnt_o(drop_cnt)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one cycle of stimulus plus reference model update
  task automatic drive(logic v, logic [ADDR_W-1:0] a, logic [STATE_W-1:0] s,
                       logic w = 1'b0, logic [WIN_W-1:0] waddr = '0, logic [7:0] wdata = '0);
    @(negedge clk);
    fv = v; fa = a; st = s; we = w; wa = waddr; wd = wdata;
    if (v && a[ADDR_W-1:WIN_W] == '0) begin
      logic [7:0] e;
      logic [3:0] op, id;
      logic       emit;
      logic [VAL_W-1:0] val;
      rec_t r;
      e = m_mem[a[WIN_W-1:0]];
      op = e[7:4]; id = e[3:0];
      emit = 1'b0; val = m_cnt[id];
      case (op)
        4'd1: m_flag[id] = 1'b1;
        4'd2: m_flag[id] = 1'b0;
        4'd3: emit = m_flag[id];
        4'd4: emit = 1'b1;
        4'd5: m_cnt[id] = m_cnt[id] + 1'b1;
        4'd6: m_start[id] = VAL_W'(cyc);
        4'd7: begin emit = 1'b1; val = VAL_W'(cyc) - m_start[id]; end
        default: ;
      endcase
      if (emit) begin
        r.ts = VAL_W'(cyc); r.addr = a[WIN_W-1:0]; r.id = id; r.op = op;
        r.val = val; r.state = s; r.tag = cur_tag;
        if (!rdy && q.size() >= DEPTH) drop_exp++;
        else q.push_back(r);
      end
    end
    if (w) m_mem[waddr] = wdata;
  endtask

  task automatic idle(int n = 1);
    for (int i = 0; i < n; i++) drive(1'b0, '0, '0);
  endtask

  task automatic fetch(int idx, logic [STATE_W-1:0] s);
    drive(1'b1, ADDR_W'(idx), s);
  endtask

  // monitor: compares each record as it leaves the FIFO
  always @(negedge clk) begin
    #(CLK_PERIOD/4);
    if (rst_n && evt_valid && rdy) begin
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL unexpected record: actual addr=%0h op=%0h id=%0h expected none (R3/R4/R9)",
                 evt_addr, evt_op, evt_id);
      end else begin
        rec_t r;
        r = q.pop_front();
        if ({evt_ts, evt_addr, evt_id, evt_op, evt_val, evt_state} !==
            {r.ts, r.addr, r.id, r.op, r.val, r.state}) begin
          errors++;
          $display("FAIL %s R8: actual ts=%0h addr=%0h id=%0h op=%0h val=%0h st=%0h expected ts=%0h addr=%0h id=%0h op=%0h val=%0h st=%0h",
                   r.tag, evt_ts, evt_addr, evt_id, evt_op, evt_val, evt_state,
                   r.ts, r.addr, r.id, r.op, r.val, r.state);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin
    for (int i = 0; i < 16; i++) begin m_cnt[i] = '0; m_start[i] = '0; end
    for (int i = 0; i < (1 << WIN_W); i++) m_mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R12 reset valid", 32'(evt_valid), 0);
    chk("R12 reset ovf", 32'(ovf), 0);
    chk("R12 reset drop", 32'(drop_cnt), 0);

    // program entries: opcode [7:4], ID [3:0]
    drive(0, '0, '0, 1, 10'd0, 8'h43);
    drive(0, '0, '0, 1, 10'd1, 8'h53);
    drive(0, '0, '0, 1, 10'd2, 8'h15);
    drive(0, '0, '0, 1, 10'd3, 8'h35);
    drive(0, '0, '0, 1, 10'd4, 8'h25);
    drive(0, '0, '0, 1, 10'd5, 8'h67);
    drive(0, '0, '0, 1, 10'd6, 8'h77);
    drive(0, '0, '0, 1, 10'd7, 8'h93);
    drive(0, '0, '0, 1, 10'd8, 8'h00);
    drive(0, '0, '0, 1, 10'd9, 8'h41);
    drive(0, '0, '0, 1, 10'd10, 8'h00);
    drive(0, '0, '0, 1, 10'd1023, 8'h4a);
    idle(2);

    cur_tag = "R5 emit R2";
    fetch(0, 8'hA5); idle(2);
    cur_tag = "R6 count R3 back-to-back";
    fetch(1, 8'h01); fetch(1, 8'h02); fetch(1, 8'h03); fetch(0, 8'h3C); idle(2);
    cur_tag = "R4 flag test";
    fetch(3, 8'h10); fetch(2, 8'h11); fetch(3, 8'h12); fetch(4, 8'h13); fetch(3, 8'h14); idle(2);
    cur_tag = "R7 timer";
    fetch(5, 8'h20); idle(3); fetch(6, 8'h21); idle(2);
    cur_tag = "R9 reserved";
    fetch(7, 8'h30); fetch(8, 8'h31); fetch(0, 8'h32); idle(2);
    cur_tag = "R1 window";
    drive(1, 32'h0000_0400, 8'h40);
    drive(1, 32'h8000_0001, 8'h41);
    drive(0, 32'h0, 8'h42);
    fetch(0, 8'h43); fetch(1023, 8'h44); idle(2);
    cur_tag = "R11 collision";
    drive(1, 32'd10, 8'h50, 1, 10'd10, 8'h42);
    fetch(10, 8'h51); idle(2);

    cur_tag = "R10 overflow R12 order";
    idle(2);
    rdy = 1'b0;
    for (int i = 0; i < 6; i++) fetch(9, STATE_W'(8'h60 + i));
    idle(3);
    chk("R10 ovf sticky", 32'(ovf), 1);
    chk("R10 drop count", 32'(drop_cnt), 32'(drop_exp));
    chk("R10 drop expected 2", 32'(drop_exp), 2);
    chk("R12 head waiting", 32'(evt_valid), 1);
    @(negedge clk); rdy = 1'b1;
    idle(8);
    chk("R12 drained", 32'(evt_valid), 0);
    chk("R10 ovf held after drain", 32'(ovf), 1);
    chk("R3 all records delivered", 32'(q.size()), 0);
    summary();
  end
endmodule